// File: doc/BRIEF.md
# Power-Fail Supervisor with Gated Memory Enable

This block sits between a supply comparator and the rest of a board-level system. A digital power-good level comes in from that comparator. From it, the block sequences three things: the processor's active-low reset, a power-fail interrupt, and the active-low chip enable of an external battery-backed memory. Every delay is counted in cycles of a reference clock and set by parameters. A bench can therefore shrink the 200 ms reset stretch, the 100 µs drain window and the memory recovery time to a few cycles. A watchdog-timeout level from elsewhere in the system also pulls reset low.

Reset is handled by three states. `RS_DOWN` holds reset while power is bad and moves to `RS_STRETCH` on the first clock edge that samples power good. `RS_STRETCH` counts good edges. It falls back to `RS_DOWN` on any dip, which restarts the count, and moves to `RS_UP` when the count completes. `RS_UP` returns to `RS_DOWN` when power is lost.

The chip-enable gate uses four states:
- `CE_PASS` passes the input straight to the output. On power loss it goes to `CE_DRAIN` if the input is low at that edge, and to `CE_BLOCK` otherwise.
- `CE_DRAIN` keeps following the input so that a memory cycle already in progress can finish. It goes to `CE_BLOCK` when the input rises or when the drain window expires.
- `CE_BLOCK` holds the output high and goes to `CE_RECOVER` on the first good edge.
- `CE_RECOVER` holds the output high while it counts. It returns to `CE_BLOCK` on a dip and goes to `CE_PASS` when the count completes.

Top module: `pfs_supervisor`

## Requirements
- R1: `rst_out_n` is low in any cycle in which `pwr_good` is 0 or `wd_timeout` is 1, combinationally with those inputs.
- R2: After power returns, `rst_out_n` stays low until `pwr_good` has been sampled 1 on STRETCH_CYC+1 consecutive rising edges. From then on it is high, provided `wd_timeout` is 0.
- R3: A dip of `pwr_good` to 0, sampled on any edge before the stretch completes, restarts the count of R2 from zero.
- R4: While the gate is in pass-through, `ceout_n` equals `cein_n` combinationally.
- R5: If the first edge that samples `pwr_good`=0 also samples `cein_n`=1, `ceout_n` is forced to 1. It then ignores `cein_n` until recovery completes.
- R6: If that edge samples `cein_n`=0, `ceout_n` follows `cein_n` (the drain window). The window ends when an edge samples `cein_n`=1, or at the HOLD_CYC-th edge after the failure edge, whichever comes first. After that `ceout_n` is forced to 1 as in R5.
- R7: When forced high, `ceout_n` returns to pass-through only after `pwr_good` has been sampled 1 on RECOV_CYC+1 consecutive edges. A dip restarts this count.
- R8: A rising edge that samples `pwr_good`=0 after an edge that sampled it 1 sets `pf_flag`. `irq_n` is low exactly when `pf_flag`=1 and `pf_irq_en`=1.
- R9: An edge that samples `flag_rd`=1 clears `pf_flag`, unless the same edge sets it per R8, in which case set wins.
- R10: While `sys_rst_n` is low, `rst_out_n`=0, `ceout_n`=1, `pf_flag`=0 and `irq_n`=1. The power-good history is treated as "bad".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for all delay counts |
| sys_rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Synchronous power-good level from the comparator |
| wd_timeout | input | 1 | Watchdog timeout level; forces reset low |
| cein_n | input | 1 | Active-low chip-enable request for external memory |
| pf_irq_en | input | 1 | Enables the power-fail interrupt |
| flag_rd | input | 1 | Read strobe that clears the power-fail flag |
| rst_out_n | output | 1 | Active-low system reset |
| ceout_n | output | 1 | Gated active-low chip enable to external memory |
| pf_flag | output | 1 | Power-fail event flag |
| irq_n | output | 1 | Active-low power-fail interrupt |

## Verification
A stuck or wrong reset state shows up on `rst_out_n` no later than STRETCH_CYC+1 cycles after power returns, either as an early release or as a release that never comes. A wrong chip-enable state shows up either as a memory enable that leaks during failure, visible in the same cycle in which `cein_n` toggles, or as a pass-through that reopens too early or too late relative to RECOV_CYC. The reference model tracks consecutive good edges and the drain age as plain integers and compares every output on every cycle. A flag state error therefore appears on `pf_flag` or `irq_n` at the edge just after the fall or the read.

// File: rtl/pfs_pkg.sv
`timescale 1ns/1ps
package pfs_pkg;

    typedef enum logic [1:0] {
        RS_DOWN    = 2'd0,
        RS_STRETCH = 2'd1,
        RS_UP      = 2'd2
    } rs_state_e;

    typedef enum logic [1:0] {
        CE_BLOCK   = 2'd0,
        CE_RECOVER = 2'd1,
        CE_PASS    = 2'd2,
        CE_DRAIN   = 2'd3
    } ce_state_e;

    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim > 1) ? $clog2(lim) : 1;
    endfunction

endpackage

// File: rtl/pfs_cycle_timer.sv
`timescale 1ns/1ps
module pfs_cycle_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic last
);
    localparam int unsigned CW = pfs_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_VAL); // R2

endmodule

// File: rtl/pfs_reset_seq.sv
`timescale 1ns/1ps
module pfs_reset_seq #(
    parameter int unsigned STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic wd_timeout,
    output logic rst_out_n
);
    import pfs_pkg::*;

    rs_state_e state_q, state_d;
    logic      stretch_done;

    pfs_cycle_timer #(.LIMIT(STRETCH_CYC)) stretch_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != RS_STRETCH),
        .run   (state_q == RS_STRETCH),
        .last  (stretch_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_DOWN:    if (pwr_good) state_d = RS_STRETCH;
            RS_STRETCH: begin
                if (!pwr_good)         state_d = RS_DOWN;
                else if (stretch_done) state_d = RS_UP;
            end
            RS_UP:      if (!pwr_good) state_d = RS_DOWN;
            default:    state_d = RS_DOWN;
        endcase
    end

    always_comb begin
        rst_out_n = 1'b0;
        unique case (state_q)
            RS_UP:   rst_out_n = pwr_good && !wd_timeout;
            default: rst_out_n = 1'b0;
        endcase
    end

    AST_UP_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_UP) |-> $past(pwr_good)); // R2
    AST_DIP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_STRETCH && !pwr_good) |=> (state_q == RS_DOWN)); // R3

endmodule

// File: rtl/pfs_ce_gate.sv
`timescale 1ns/1ps
module pfs_ce_gate #(
    parameter int unsigned HOLD_CYC  = 8,
    parameter int unsigned RECOV_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic cein_n,
    output logic ceout_n
);
    import pfs_pkg::*;

    ce_state_e state_q, state_d;
    logic      recov_done;
    logic      drain_done;

    pfs_cycle_timer #(.LIMIT(RECOV_CYC)) recov_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != CE_RECOVER),
        .run   (state_q == CE_RECOVER),
        .last  (recov_done)
    );

    pfs_cycle_timer #(.LIMIT(HOLD_CYC)) drain_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != CE_DRAIN),
        .run   (state_q == CE_DRAIN),
        .last  (drain_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CE_BLOCK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CE_BLOCK:   if (pwr_good) state_d = CE_RECOVER;
            CE_RECOVER: begin
                if (!pwr_good)       state_d = CE_BLOCK;
                else if (recov_done) state_d = CE_PASS;
            end
            CE_PASS: begin
                if (!pwr_good) state_d = cein_n ? CE_BLOCK : CE_DRAIN;
            end
            CE_DRAIN: begin
                if (cein_n || drain_done) state_d = CE_BLOCK;
            end
            default: state_d = CE_BLOCK;
        endcase
    end

    always_comb begin
        ceout_n = 1'b1;
        unique case (state_q)
            CE_PASS, CE_DRAIN:     ceout_n = cein_n;
            CE_BLOCK, CE_RECOVER:  ceout_n = 1'b1;
            default:               ceout_n = 1'b1;
        endcase
    end

    AST_PASS_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CE_PASS) |-> $past(pwr_good)); // R7
    AST_DRAIN_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CE_DRAIN) |=> (state_q != CE_PASS)); // R6

endmodule

// File: rtl/pfs_fail_flag.sv
`timescale 1ns/1ps
module pfs_fail_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic flag_rd,
    input  logic irq_en,
    output logic pf_flag,
    output logic irq_n
);
    logic pg_q;
    logic fall_evt;

    assign fall_evt = pg_q && !pwr_good;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q    <= 1'b0;
            pf_flag <= 1'b0;
        end else begin
            pg_q <= pwr_good;
            if (fall_evt)     pf_flag <= 1'b1;
            else if (flag_rd) pf_flag <= 1'b0;
        end
    end

    assign irq_n = !(pf_flag && irq_en);

    AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> pf_flag); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !fall_evt) |=> !pf_flag); // R9

endmodule

// File: rtl/pfs_supervisor.sv
`timescale 1ns/1ps
module pfs_supervisor #(
    parameter int unsigned STRETCH_CYC = 200000,
    parameter int unsigned HOLD_CYC    = 100,
    parameter int unsigned RECOV_CYC   = 200000
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic pwr_good,
    input  logic wd_timeout,
    input  logic cein_n,
    input  logic pf_irq_en,
    input  logic flag_rd,
    output logic rst_out_n,
    output logic ceout_n,
    output logic pf_flag,
    output logic irq_n
);

    pfs_reset_seq #(.STRETCH_CYC(STRETCH_CYC)) reset_seq_i (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .pwr_good   (pwr_good),
        .wd_timeout (wd_timeout),
        .rst_out_n  (rst_out_n)
    );

    pfs_ce_gate #(.HOLD_CYC(HOLD_CYC), .RECOV_CYC(RECOV_CYC)) ce_gate_i (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .pwr_good (pwr_good),
        .cein_n   (cein_n),
        .ceout_n  (ceout_n)
    );

    pfs_fail_flag fail_flag_i (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .pwr_good (pwr_good),
        .flag_rd  (flag_rd),
        .irq_en   (pf_irq_en),
        .pf_flag  (pf_flag),
        .irq_n    (irq_n)
    );

    AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(rst_out_n) |-> $past(pwr_good)); // R1
    AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!pwr_good && $past(!pwr_good) && $past(ceout_n)) |-> ceout_n); // R5

endmodule

// File: tb/pfs_supervisor_tb.sv
`timescale 1ns/1ps
module pfs_supervisor_tb_top;

    localparam int S = 12;
    localparam int H = 5;
    localparam int R = 8;

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic pwr_good = 1'b0, wd_timeout = 1'b0, cein_n = 1'b1;
    logic pf_irq_en = 1'b0, flag_rd = 1'b0;
    logic rst_out_n, ceout_n, pf_flag, irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string req_tag = "R10";

    always #2 clk = ~clk;

    pfs_supervisor #(.STRETCH_CYC(S), .HOLD_CYC(H), .RECOV_CYC(R)) dut_i (
        .clk(clk), .sys_rst_n(sys_rst_n), .pwr_good(pwr_good),
        .wd_timeout(wd_timeout), .cein_n(cein_n), .pf_irq_en(pf_irq_en),
        .flag_rd(flag_rd), .rst_out_n(rst_out_n), .ceout_n(ceout_n),
        .pf_flag(pf_flag), .irq_n(irq_n));

    // Behavioural reference model
    int good_run = 0;
    bit pg_prev = 0, m_flag = 0, m_pass = 0, m_drain_on = 0;
    int m_drain = 0, m_rec = 0;

    always @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            good_run = 0; pg_prev = 0; m_flag = 0;
            m_pass = 0; m_drain_on = 0; m_drain = 0; m_rec = 0;
        end else begin
            good_run = pwr_good ? ((good_run < 1000000) ? good_run + 1 : good_run) : 0;
            if (pg_prev && !pwr_good) m_flag = 1;
            else if (flag_rd)         m_flag = 0;
            pg_prev = pwr_good;
            if (m_pass) begin
                if (!pwr_good) begin
                    m_pass = 0; m_rec = 0;
                    if (!cein_n) begin m_drain_on = 1; m_drain = 0; end
                end
            end else if (m_drain_on) begin
                if (cein_n || m_drain == H - 1) m_drain_on = 0;
                else m_drain++;
            end else begin
                m_rec = pwr_good ? m_rec + 1 : 0;
                if (m_rec == R + 1) begin m_pass = 1; m_rec = 0; end
            end
        end
    end

    task automatic check(input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", req_tag, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic e_rst, e_ce, e_irq;
        cyc++;
        e_rst = sys_rst_n && pwr_good && !wd_timeout && (good_run >= S + 1);
        e_ce  = (sys_rst_n && (m_pass || m_drain_on)) ? cein_n : 1'b1;
        e_irq = !(m_flag && pf_irq_en);
        check("rst_out_n", rst_out_n, e_rst);
        check("ceout_n", ceout_n, e_ce);
        check("pf_flag", pf_flag, m_flag);
        check("irq_n", irq_n, e_irq);
    end

    task automatic drive(input int n, input logic pg, input logic ce, input logic wd,
                         input logic rd, input logic en);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            pwr_good = pg; cein_n = ce; wd_timeout = wd; flag_rd = rd; pf_irq_en = en;
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    initial begin
        int low_cnt;
        // R10: reset state, with power good present during reset
        req_tag = "R10";
        pwr_good = 1'b1; cein_n = 1'b0; pf_irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R10 rst_out_n in reset", rst_out_n, 1'b0);
        check("R10 ceout_n in reset", ceout_n, 1'b1);
        check("R10 irq_n in reset", irq_n, 1'b1);
        @(posedge clk); #1; sys_rst_n = 1'b1;

        // R2 and R7: power up, count reset low cycles
        req_tag = "R2/R7";
        low_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!rst_out_n) low_cnt++;
            #1 cein_n = i[0];
        end
        check("R2 stretch edges counted", (low_cnt == S + 1), 1'b1);

        // R4: pass-through with various patterns
        req_tag = "R4";
        drive(1, 1, 0, 0, 0, 1); drive(1, 1, 1, 0, 0, 1);
        drive(2, 1, 0, 0, 0, 1); drive(3, 1, 1, 0, 0, 1);

        // R1: watchdog
        req_tag = "R1";
        drive(3, 1, 1, 1, 0, 1); drive(2, 1, 1, 0, 0, 1);

        // R5 and R8: fail with enable idle, toggle input while blocked
        req_tag = "R5/R8";
        drive(1, 0, 1, 0, 0, 1);
        for (int i = 0; i < 8; i++) drive(1, 0, i[0], 0, 0, 1);
        // R9: read clears while power bad; interrupt disabled view
        req_tag = "R9";
        drive(1, 0, 1, 0, 1, 0); drive(2, 0, 1, 0, 0, 1);

        // R3: dips during stretch and recovery
        req_tag = "R3/R7";
        drive(6, 1, 1, 0, 0, 1); drive(1, 0, 1, 0, 0, 1);
        drive(5, 1, 0, 0, 0, 1); drive(1, 0, 0, 0, 0, 1);
        drive(25, 1, 0, 0, 1, 1);

        // R6: drain with input held low until window closes
        req_tag = "R6";
        drive(1, 0, 0, 0, 0, 1);
        for (int i = 0; i < H + 3; i++) drive(1, 0, 0, 0, 0, 1);
        drive(2, 0, 1, 0, 0, 1);
        // R6: recover then drain ended early by input rising
        drive(25, 1, 1, 0, 1, 1);
        drive(1, 1, 0, 0, 0, 1);
        drive(2, 0, 0, 0, 0, 1); drive(1, 0, 1, 0, 0, 1);
        drive(3, 0, 0, 0, 0, 1);

        // R9: read on the same edge as a fall, set wins
        req_tag = "R9/R8";
        drive(25, 1, 1, 0, 1, 1);
        drive(1, 0, 1, 0, 1, 1);
        drive(2, 0, 1, 0, 0, 1);
        @(negedge clk);
        check("R9 set beats read", pf_flag, 1'b1);
        check("R8 irq asserted", irq_n, 1'b0);
        drive(3, 1, 1, 0, 0, 1);
        @(negedge clk);
        finish_run();
    end

endmodule